// File: doc/BRIEF.md
# Radio Configuration SPI Slave

This block is the host-facing serial port of a radio transceiver. A host talks to it over a four-wire SPI link in mode 0, most significant bit first. It reaches five targets through the link: a bank of 48 configuration registers, 14 read-only status registers, a set of command strobes, an 8-entry output-power table and the transmit and receive FIFOs. The radio state machine and the FIFO storage sit outside the block. The block takes in the main state code, the FIFO fill levels and the receive data. It gives out the register contents, one-cycle strobe pulses and FIFO push and pop strobes.

Each selection of the chip starts with a header byte. The header holds a read/write flag, a burst flag and a six-bit address. While the host clocks in a header byte or a write data byte, the slave clocks out a status byte. That byte holds a not-ready flag, the three-bit main state and a FIFO fill level that saturates at 15. The serial clock and the chip select are sampled with the system clock through two-flop synchronisers. The serial clock must therefore run several times slower than the system clock.

Top module: `rcfg_spi_slave`

## Requirements
- R1: The header byte is taken MSB first. Bit 7 is read (1) or write (0), bit 6 is the burst flag and bits 5:0 are the address. With `cs_n` high the serial bit counter is held at zero.
- R2: The slave shifts out a status byte during every header byte and every write data byte. Bit 7 is `not_ready`, bits 6:4 are `main_state` and bits 3:0 are the FIFO level. The state codes are 0 idle, 1 receive, 2 transmit, 3 synthesiser on, 4 calibrate, 5 settling, 6 receive overflow and 7 transmit underflow.
- R3: The level field is min(`rx_level`, 15) when bit 7 of the header is 1, and min(`tx_room`, 15) when it is 0. The value used is the one present while the byte is shifting, so a byte being pushed is not yet counted.
- R4: Addresses 0x00 to 0x2F select a configuration register. A single write stores the data byte. A single read returns the register on `so` during the data byte. After a single access, the next byte is a new header.
- R5: In a burst access to 0x00 to 0x2F, the register pointer moves up by one after every 8 serial clocks. Writes to a pointer past 0x2F are dropped.
- R6: A header with burst=1 and read=1 for addresses 0x30 to 0x3D returns status register (address−0x30), byte k of `stat_flat` at bits 8k+7:8k. It is a single access.
- R7: A header with burst=0 for addresses 0x30 to 0x3D raises bit (address−0x30) of `strobe` for exactly one cycle. No data byte follows, and the next byte is another header, so strobes can be chained in one selection.
- R8: Address 0x3F reaches the FIFOs. A write data byte gives a one-cycle `tx_push` with the byte on `tx_data`. A read data byte returns `rx_data` and then gives a one-cycle `rx_pop`. Single or burst follows the burst flag.
- R9: Address 0x3E reaches the 8-entry power table at an index. The index advances after every data byte and wraps from 7 to 0. It returns to 0 whenever `cs_n` is high.
- R10: If `cs_n` rises before a byte's eighth clock, the partial byte is dropped. No register, table entry or FIFO changes because of it.
- R11: `so` is high impedance while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host, high impedance when deselected |
| not_ready | input | 1 | Status bit 7 |
| main_state | input | 3 | Main state code for status bits 6:4 |
| rx_level | input | CNT_W | Bytes held in the receive FIFO |
| tx_room | input | CNT_W | Free bytes in the transmit FIFO |
| stat_flat | input | 112 | Fourteen status register bytes, byte k at bits 8k+7:8k |
| rx_data | input | 8 | Head byte of the receive FIFO |
| cfg_flat | output | 384 | Configuration registers, register k at bits 8k+7:8k |
| pa_flat | output | 64 | Power table, entry k at bits 8k+7:8k |
| strobe | output | 14 | One-cycle command strobes |
| tx_push | output | 1 | Transmit FIFO write pulse |
| tx_data | output | 8 | Byte pushed with `tx_push` |
| rx_pop | output | 1 | Receive FIFO read pulse |

## Verification
A sampled serial clock edge reaches the shift logic three system clocks after the pin changes. Register writes, pushes, pops and strobes follow one and two clocks after that. The bench holds every SCLK level for eight system clocks. It samples `so` at the end of each low phase, well after the falling-edge update. It compares register, table and FIFO effects against its behavioural model only after the selection has ended and three more half periods have passed, so no check falls inside the synchroniser latency. The one-cycle pulses are counted by a monitor on every falling system-clock edge.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
    localparam int DW        = 8;
    localparam int AW        = 6;
    localparam int CFG_REGS  = 48;
    localparam int STAT_REGS = 14;
    localparam int PA_DEPTH  = 8;
    localparam logic [AW-1:0] STAT_BASE = 6'h30;
    localparam logic [AW-1:0] PA_ADDR   = 6'h3E;
    localparam logic [AW-1:0] FIFO_ADDR = 6'h3F;

    typedef struct packed {
        logic          rd;
        logic          burst;
        logic [AW-1:0] addr;
    } hdr_t;

    typedef enum logic [1:0] {TGT_CFG, TGT_STAT, TGT_PA, TGT_FIFO} tgt_e;
    typedef enum logic {PH_HDR, PH_DATA} phase_e;

    function automatic tgt_e target_of(input logic [AW-1:0] a);
        if (a < STAT_BASE)  return TGT_CFG;
        if (a == PA_ADDR)   return TGT_PA;
        if (a == FIFO_ADDR) return TGT_FIFO;
        return TGT_STAT;
    endfunction

    function automatic logic [3:0] sat_level(input logic [15:0] n);
        return (n > 16'd15) ? 4'hF : n[3:0];
    endfunction
endpackage

// File: rtl/rcfg_spi_shift.sv
module rcfg_spi_shift
    import rcfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk_i,
    input  logic          cs_n_i,
    input  logic          mosi_i,
    input  logic [DW-1:0] so_byte_i,
    output logic          so_q_o,
    output logic          sel_o,
    output logic          byte_vld_o,
    output logic [DW-1:0] byte_o,
    output logic          lead_o
);
    localparam int BCW = $clog2(DW);

    logic [1:0]     sclk_sy, cs_sy, mosi_sy;
    logic           sclk_d, cs_d;
    logic [BCW-1:0] bit_cnt;
    logic [DW-1:0]  sr;
    logic           rise, fall, cs_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sy <= '0;
            cs_sy   <= '1;
            mosi_sy <= '0;
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            sclk_sy <= {sclk_sy[0], sclk_i};
            cs_sy   <= {cs_sy[0], cs_n_i};
            mosi_sy <= {mosi_sy[0], mosi_i};
            sclk_d  <= sclk_sy[1];
            cs_d    <= cs_sy[1];
        end
    end

    assign sel_o   = ~cs_sy[1];
    assign rise    = sel_o & sclk_sy[1] & ~sclk_d;
    assign fall    = sel_o & ~sclk_sy[1] & sclk_d;
    assign cs_fall = cs_d & ~cs_sy[1];

    always_ff @(posedge clk) begin
        if (rst || !sel_o) begin
            bit_cnt    <= '0;
            sr         <= '0;
            byte_vld_o <= 1'b0;
            so_q_o     <= 1'b0;
            if (rst) begin
                byte_o <= '0;
                lead_o <= 1'b0;
            end
        end else begin
            byte_vld_o <= 1'b0;
            if (rise) begin
                sr      <= {sr[DW-2:0], mosi_sy[1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == '0) lead_o <= mosi_sy[1];
                if (bit_cnt == BCW'(DW-1)) begin
                    byte_vld_o <= 1'b1;
                    byte_o     <= {sr[DW-2:0], mosi_sy[1]};
                end
            end
            if (cs_fall || fall) so_q_o <= so_byte_i[~bit_cnt];
        end
    end

    // R1: counter idles at zero when deselected
    a_r1_idle_count: assert property (@(posedge clk) disable iff (rst)
        !sel_o |=> bit_cnt == '0);
endmodule

// File: rtl/rcfg_regbank.sv
module rcfg_regbank
    import rcfg_pkg::*;
#(
    parameter int N_CFG = CFG_REGS,
    parameter int N_PA  = PA_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic              pa_we,
    input  logic              pa_adv,
    input  logic              pa_clr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     cfg_rdata,
    output logic [DW-1:0]     pa_rdata,
    output logic [N_CFG*DW-1:0] cfg_flat,
    output logic [N_PA*DW-1:0]  pa_flat
);
    localparam int PIW = $clog2(N_PA);

    logic [DW-1:0]  cfg_q [N_CFG];
    logic [DW-1:0]  pa_q  [N_PA];
    logic [PIW-1:0] pa_idx;

    for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)                                   cfg_q[i] <= '0;
            else if (cfg_we && cfg_addr == AW'(i))     cfg_q[i] <= wdata;
        end
        assign cfg_flat[i*DW +: DW] = cfg_q[i];
    end

    for (genvar j = 0; j < N_PA; j++) begin : g_pa
        always_ff @(posedge clk) begin
            if (rst)                                   pa_q[j] <= '0;
            else if (pa_we && pa_idx == PIW'(j))       pa_q[j] <= wdata;
        end
        assign pa_flat[j*DW +: DW] = pa_q[j];
    end

    always_ff @(posedge clk) begin
        if (rst || pa_clr)  pa_idx <= '0;
        else if (pa_adv)    pa_idx <= (pa_idx == PIW'(N_PA-1)) ? '0 : pa_idx + 1'b1;
    end

    assign cfg_rdata = (int'(cfg_addr) < N_CFG) ? cfg_q[cfg_addr] : '0;
    assign pa_rdata  = pa_q[pa_idx];

    // R9: index returns to zero while deselected
    a_r9_index_clear: assert property (@(posedge clk) disable iff (rst)
        pa_clr |=> pa_idx == '0);
    // R9: index wraps from the last entry
    a_r9_index_wrap: assert property (@(posedge clk) disable iff (rst)
        (pa_adv && !pa_clr && pa_idx == PIW'(N_PA-1)) |=> pa_idx == '0);
endmodule

// File: rtl/rcfg_spi_slave.sv
module rcfg_spi_slave
    import rcfg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk,
    input  logic                    cs_n,
    input  logic                    mosi,
    output logic                    so,
    input  logic                    not_ready,
    input  logic [2:0]              main_state,
    input  logic [CNT_W-1:0]        rx_level,
    input  logic [CNT_W-1:0]        tx_room,
    input  logic [STAT_REGS*DW-1:0] stat_flat,
    input  logic [DW-1:0]           rx_data,
    output logic [CFG_REGS*DW-1:0]  cfg_flat,
    output logic [PA_DEPTH*DW-1:0]  pa_flat,
    output logic [STAT_REGS-1:0]    strobe,
    output logic                    tx_push,
    output logic [DW-1:0]           tx_data,
    output logic                    rx_pop
);
    logic          so_q, sel, byte_vld, lead;
    logic [DW-1:0] byte_in, so_byte, read_byte, cfg_rdata, pa_rdata, stat_byte;
    hdr_t          hdr_in, hdr_q;
    phase_e        phase;
    tgt_e          tgt_in, tgt_q;
    logic [AW-1:0] ptr, stat_off;
    logic          rd_eff, data_done, hdr_done;
    logic [3:0]    level;

    rcfg_spi_shift u_shift (
        .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .so_byte_i(so_byte), .so_q_o(so_q), .sel_o(sel),
        .byte_vld_o(byte_vld), .byte_o(byte_in), .lead_o(lead)
    );

    assign hdr_in    = hdr_t'(byte_in);
    assign tgt_in    = target_of(hdr_in.addr);
    assign tgt_q     = target_of(hdr_q.addr);
    assign hdr_done  = byte_vld && phase == PH_HDR;
    assign data_done = byte_vld && phase == PH_DATA;

    rcfg_regbank u_bank (
        .clk(clk), .rst(rst),
        .cfg_we(data_done && !hdr_q.rd && tgt_q == TGT_CFG),
        .cfg_addr(ptr),
        .pa_we(data_done && !hdr_q.rd && tgt_q == TGT_PA),
        .pa_adv(data_done && tgt_q == TGT_PA),
        .pa_clr(!sel),
        .wdata(byte_in),
        .cfg_rdata(cfg_rdata), .pa_rdata(pa_rdata),
        .cfg_flat(cfg_flat), .pa_flat(pa_flat)
    );

    // status byte: the read flag of the header in flight is its first bit
    assign rd_eff = (phase == PH_HDR) ? lead : hdr_q.rd;
    assign level  = rd_eff ? sat_level(16'(rx_level)) : sat_level(16'(tx_room));

    assign stat_off  = hdr_q.addr - STAT_BASE;
    assign stat_byte = (int'(stat_off) < STAT_REGS) ? stat_flat[stat_off*DW +: DW] : '0;

    always_comb begin
        unique case (tgt_q)
            TGT_CFG:  read_byte = cfg_rdata;
            TGT_STAT: read_byte = stat_byte;
            TGT_PA:   read_byte = pa_rdata;
            default:  read_byte = rx_data;
        endcase
        if (phase == PH_DATA && hdr_q.rd) so_byte = read_byte;
        else                              so_byte = {not_ready, main_state, level};
    end

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            phase   <= PH_HDR;
            strobe  <= '0;
            tx_push <= 1'b0;
            rx_pop  <= 1'b0;
            if (rst) begin
                hdr_q   <= '0;
                ptr     <= '0;
                tx_data <= '0;
            end
        end else begin
            strobe  <= '0;
            tx_push <= 1'b0;
            rx_pop  <= 1'b0;
            if (hdr_done) begin
                hdr_q <= hdr_in;
                ptr   <= hdr_in.addr;
                if (tgt_in != TGT_STAT)
                    phase <= PH_DATA;
                else if (!hdr_in.burst)
                    strobe[stat_off_of(hdr_in.addr)] <= 1'b1;
                else if (hdr_in.rd)
                    phase <= PH_DATA;
            end
            if (data_done) begin
                if (!hdr_q.burst || tgt_q == TGT_STAT) phase <= PH_HDR;
                if (tgt_q == TGT_CFG) ptr <= ptr + 1'b1;
                if (tgt_q == TGT_FIFO) begin
                    if (hdr_q.rd) rx_pop <= 1'b1;
                    else begin
                        tx_push <= 1'b1;
                        tx_data <= byte_in;
                    end
                end
            end
        end
    end

    function automatic logic [$clog2(STAT_REGS)-1:0] stat_off_of(input logic [AW-1:0] a);
        logic [AW-1:0] d;
        d = a - STAT_BASE;
        return d[$clog2(STAT_REGS)-1:0];
    endfunction

    assign so = sel ? so_q : 1'bz;

    // R7: at most one strobe per cycle
    a_r7_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));
    // R8: push and pop never together
    a_r8_push_pop_excl: assert property (@(posedge clk) disable iff (rst)
        !(tx_push && rx_pop));
    // R10: a push follows only a completed byte
    a_r10_push_after_byte: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> $past(byte_vld));
    // R1: deselection returns the parser to header phase
    a_r1_header_on_idle: assert property (@(posedge clk) disable iff (rst)
        !sel |=> phase == PH_HDR);
endmodule

// File: tb/rcfg_spi_slave_bench.sv
`timescale 1ns/1ps
module rcfg_spi_slave_bench;
    localparam int H = 8;

    logic clk = 0, rst = 1;
    logic sclk = 0, cs_n = 1, mosi = 0;
    wire  so;
    logic not_ready = 0;
    logic [2:0] main_state = 3'd1;
    logic [6:0] rx_level = 7'd5, tx_room = 7'd20;
    logic [111:0] stat_flat;
    logic [7:0] rx_data;
    logic [383:0] cfg_flat;
    logic [63:0] pa_flat;
    logic [13:0] strobe;
    logic tx_push, rx_pop;
    logic [7:0] tx_data;

    always #2 clk = ~clk;

    for (genvar k = 0; k < 14; k++) begin : g_stat
        assign stat_flat[k*8 +: 8] = 8'h80 + 8'(k);
    end

    rcfg_spi_slave u_rcfg_spi_slave (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .so(so),
        .not_ready(not_ready), .main_state(main_state), .rx_level(rx_level),
        .tx_room(tx_room), .stat_flat(stat_flat), .rx_data(rx_data),
        .cfg_flat(cfg_flat), .pa_flat(pa_flat), .strobe(strobe),
        .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] txb [32];
    logic [7:0] rxb [32];
    logic [7:0] exp_cfg [48];
    logic [7:0] exp_pa [8];
    logic [7:0] rx_mem [8];
    logic [7:0] pushq [$];
    int rx_head = 0, pop_cnt = 0;
    int strobe_cnt [14];

    assign rx_data = rx_mem[rx_head[2:0]];

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_push) pushq.push_back(tx_data);
            if (rx_pop) begin rx_head++; pop_cnt++; end
            for (int i = 0; i < 14; i++) if (strobe[i]) strobe_cnt[i]++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_byte(input bit rd);
        logic [6:0] n;
        n = rd ? rx_level : tx_room;
        return {not_ready, main_state, (n > 15) ? 4'hF : n[3:0]};
    endfunction

    task automatic wait_h(input int n);
        repeat (n * H) @(negedge clk);
    endtask

    task automatic sbit(input logic v, input int i, input int b);
        mosi = v;
        wait_h(1);
        rxb[i][b] = so;
        sclk = 1;
        wait_h(1);
        sclk = 0;
    endtask

    task automatic frame(input int nbytes, input int cut_bits);
        cs_n = 0;
        wait_h(1);
        for (int i = 0; i < nbytes; i++)
            for (int b = 7; b >= 0; b--) sbit(txb[i][b], i, b);
        for (int b = 7; b > 7 - cut_bits; b--) sbit(txb[nbytes][b], nbytes, b);
        wait_h(1);
        cs_n = 1;
        wait_h(3);
    endtask

    task automatic cmp_cfg(input string req);
        for (int i = 0; i < 48; i++)
            chk(cfg_flat[i*8 +: 8] === exp_cfg[i], req, 64'(cfg_flat[i*8 +: 8]), 64'(exp_cfg[i]));
    endtask

    initial begin
        for (int i = 0; i < 48; i++) exp_cfg[i] = 8'h00;
        for (int i = 0; i < 8; i++) begin exp_pa[i] = 8'h00; rx_mem[i] = 8'h5A + 8'(i * 7); end
        for (int i = 0; i < 14; i++) strobe_cnt[i] = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);

        // R11 / reset state
        chk(so === 1'bz, "R11 so idle", 64'(so), 64'h0);
        chk(cfg_flat === '0 && pa_flat === '0 && strobe === '0, "R4 reset state", 64'(cfg_flat[63:0]), 64'h0);

        // R2 R3: status on read header, then read of cfg 5 (still zero)
        txb[0] = 8'h85; txb[1] = 8'h00;
        frame(2, 0);
        chk(rxb[0] === stat_byte(1), "R3 read level", 64'(rxb[0]), 64'(stat_byte(1)));
        chk(rxb[1] === 8'h00, "R4 read reset reg", 64'(rxb[1]), 64'h0);

        // R3: write header level saturates, R4 single write
        txb[0] = 8'h05; txb[1] = 8'hA5;
        frame(2, 0);
        exp_cfg[5] = 8'hA5;
        chk(rxb[0] === 8'h1F, "R3 saturated write level", 64'(rxb[0]), 64'h1F);
        chk(rxb[1] === 8'h1F, "R2 status on write data", 64'(rxb[1]), 64'h1F);
        cmp_cfg("R4 single write");

        // R2: not-ready and state code 6, single read back
        not_ready = 1; main_state = 3'd6;
        txb[0] = 8'h85; txb[1] = 8'h00;
        frame(2, 0);
        chk(rxb[0] === 8'hE5, "R2 status fields", 64'(rxb[0]), 64'hE5);
        chk(rxb[1] === 8'hA5, "R4 single read", 64'(rxb[1]), 64'hA5);
        not_ready = 0; main_state = 3'd2;

        // R5: burst write 10..13 then burst read; burst write past 0x2F dropped
        txb[0] = 8'h4A; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33; txb[4] = 8'h44;
        frame(5, 0);
        exp_cfg[10] = 8'h11; exp_cfg[11] = 8'h22; exp_cfg[12] = 8'h33; exp_cfg[13] = 8'h44;
        txb[0] = 8'hCA; for (int i = 1; i < 5; i++) txb[i] = 8'h00;
        frame(5, 0);
        for (int i = 1; i < 5; i++)
            chk(rxb[i] === exp_cfg[9 + i], "R5 burst read", 64'(rxb[i]), 64'(exp_cfg[9 + i]));
        txb[0] = 8'h6E; txb[1] = 8'hC1; txb[2] = 8'hC2; txb[3] = 8'hC3;
        frame(4, 0);
        exp_cfg[46] = 8'hC1; exp_cfg[47] = 8'hC2;
        cmp_cfg("R5 burst write with end of range");

        // R6: status register 1, then next byte is a header
        txb[0] = 8'hF1; txb[1] = 8'h00; txb[2] = 8'h85; txb[3] = 8'h00;
        frame(4, 0);
        chk(rxb[1] === 8'h81, "R6 status register read", 64'(rxb[1]), 64'h81);
        chk(rxb[3] === 8'hA5, "R6 single access then header", 64'(rxb[3]), 64'hA5);

        // R7: chained strobes 0x33 and 0x36 (write), 0x3D (read, burst 0)
        txb[0] = 8'h33; txb[1] = 8'h36; txb[2] = 8'hBD;
        frame(3, 0);
        chk(strobe_cnt[3] == 1 && strobe_cnt[6] == 1 && strobe_cnt[13] == 1, "R7 strobes",
            64'(strobe_cnt[3] + 10 * strobe_cnt[6] + 100 * strobe_cnt[13]), 64'd111);
        chk(rxb[1] === stat_byte(0), "R7 status on chained header", 64'(rxb[1]), 64'(stat_byte(0)));
        cmp_cfg("R7 strobes leave registers");

        // R8: transmit FIFO burst write, level counted before each push
        tx_room = 7'd3;
        txb[0] = 8'h7F; txb[1] = 8'hD1; txb[2] = 8'hD2; txb[3] = 8'hD3;
        frame(4, 0);
        chk(pushq.size() == 3, "R8 push count", 64'(pushq.size()), 64'd3);
        if (pushq.size() == 3)
            for (int i = 0; i < 3; i++)
                chk(pushq[i] === txb[i + 1], "R8 push data", 64'(pushq[i]), 64'(txb[i + 1]));
        chk(rxb[2] === stat_byte(0), "R3 write data level", 64'(rxb[2]), 64'(stat_byte(0)));

        // R8: receive FIFO burst read
        txb[0] = 8'hFF; txb[1] = 8'h00; txb[2] = 8'h00;
        frame(3, 0);
        chk(rxb[1] === rx_mem[0] && rxb[2] === rx_mem[1], "R8 fifo read data",
            64'({rxb[1], rxb[2]}), 64'({rx_mem[0], rx_mem[1]}));
        chk(pop_cnt == 2, "R8 pop count", 64'(pop_cnt), 64'd2);

        // R9: power table burst of 9 wraps, index resets on deselect
        txb[0] = 8'h7E;
        for (int i = 1; i <= 9; i++) txb[i] = 8'h60 + 8'(i);
        frame(10, 0);
        for (int i = 1; i <= 9; i++) exp_pa[(i - 1) % 8] = txb[i];
        for (int i = 0; i < 8; i++)
            chk(pa_flat[i*8 +: 8] === exp_pa[i], "R9 table contents", 64'(pa_flat[i*8 +: 8]), 64'(exp_pa[i]));
        txb[0] = 8'hBE; txb[1] = 8'h00;
        frame(2, 0);
        chk(rxb[1] === exp_pa[0], "R9 index reset", 64'(rxb[1]), 64'(exp_pa[0]));

        // R10: cut frames change nothing
        txb[0] = 8'h07; txb[1] = 8'hFF;
        frame(1, 4);
        cmp_cfg("R10 cut register write");
        txb[0] = 8'h7F; txb[1] = 8'hEE;
        frame(1, 7);
        chk(pushq.size() == 3, "R10 cut fifo write", 64'(pushq.size()), 64'd3);
        txb[0] = 8'h3E; txb[1] = 8'h12;
        frame(1, 5);
        chk(pa_flat === {exp_pa[7], exp_pa[6], exp_pa[5], exp_pa[4], exp_pa[3], exp_pa[2], exp_pa[1], exp_pa[0]},
            "R10 cut table write", 64'(pa_flat), 64'h0);
        txb[0] = 8'h07; txb[1] = 8'h99;
        frame(2, 0);
        exp_cfg[7] = 8'h99;
        cmp_cfg("R1 frame after cut");
        chk(so === 1'bz, "R11 so after frames", 64'(so), 64'h0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule